// File: doc/BRIEF.md
# Address Match Debug Trigger Bank

This block holds a small bank of hardware breakpoint and watchpoint triggers for a 32-bit core. Each trigger has a configuration word and a 32-bit compare value. Both are written and read back through a simple register port. The core presents one access per cycle on an access port. An access carries its kind (instruction execute, load or store), the current privilege mode and the address. Each trigger decides whether the access matches its address condition. When a group of triggers hits, the block raises a request to enter debug mode. The request is marked as either before or after the access.

The address conditions are exact equality, a naturally aligned power-of-two region, greater-or-equal, less-than, and a masked compare against either the low or the high 16 address bits. A trigger can be chained to the next one, so that a single event fires only when every trigger in the chain matches the same access. Two chained triggers give an inclusive-start, exclusive-end range, or a low-half and high-half pair. A debugger learns whether a setting is supported by writing it and reading it back. Unsupported settings therefore read back as zero and leave the trigger inert.

Top module: `dbg_trig_bank`

## Requirements
- R1: Configuration bits are load enable bit 0, store enable bit 1, execute enable bit 2, user enable bit 3, supervisor enable bit 4, machine enable bit 6, match mode bits 10:7, chain bit 11, action bits 15:12 and timing bit 18. Every other bit reads 0. A compare value reads back exactly as written. Selecting `rd_sel`=0 reads the configuration word and `rd_sel`=1 reads the compare value.
- R2: A configuration write with a match mode above 5, or with an action other than 1, stores all zeros, and the trigger then never fires.
- R3: The chain bit of the last trigger always reads 0; the rest of that write is kept.
- R4: An access matches only if its kind is enabled. The kind encoding is 0 execute, 1 load, 2 store, and 3 no kind.
- R5: An access matches only if its privilege is enabled. The privilege encoding is 0 user, 1 supervisor and 3 machine. Privilege code 2 never matches.
- R6: Mode 0 matches when the address equals the compare value.
- R7: Mode 1 ignores the address bits covered by the compare value's trailing ones and the zero just above them. The remaining bits must be equal; for example 0x81237fff covers 0x81230000 through 0x8123ffff.
- R8: Mode 2 matches when the address is greater than or equal to the compare value, and mode 3 when it is less, both unsigned.
- R9: Mode 4 matches when the low 16 address bits, ANDed with compare bits 31:16, equal compare bits 15:0. Mode 5 does the same with the high 16 address bits.
- R10: A group is a run of triggers linked by set chain bits. A group fires only when all of its triggers match the same access. A firing group sets the `fire_vec` bit of its first trigger.
- R11: The timing bit of a group's first trigger selects the request: 0 raises `dbg_req_before`, 1 raises `dbg_req_after`.
- R12: Requests and `fire_vec` are registered and appear in the cycle after the access. They stay low for any cycle without `acc_valid`. Reset clears all registers and outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 writes the configuration word, 1 writes the compare value |
| wr_idx | input | IDX_W | Trigger index being written |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | 0 reads the configuration word, 1 reads the compare value |
| rd_idx | input | IDX_W | Trigger index being read |
| rd_data | output | 32 | Combinational readback |
| acc_valid | input | 1 | Access present this cycle |
| acc_kind | input | 2 | Access kind: 0 execute, 1 load, 2 store |
| acc_priv | input | 2 | Privilege: 0 user, 1 supervisor, 3 machine |
| acc_addr | input | 32 | Access address |
| dbg_req_before | output | 1 | Enter-debug request that fires before the access |
| dbg_req_after | output | 1 | Enter-debug request that fires after the access |
| fire_vec | output | NUM_TRIG | One bit per group start that fired |

## Verification
The bench probes both edges of each range. These are the inclusive start, the last covered address and the first address past the end of the greater-or-equal/less-than pair. It also uses the first and last address of a power-of-two region and the address one above it. A comparator that is off by one, or a region mask that is one bit too wide or too narrow, misses or over-fires at exactly these points.

The masked-half pair is driven with addresses where only the low half matches. A chain that fires on any single member would request debug there. Unsupported match and action codes, and a chain bit on the last trigger, are checked both through readback and through accesses that must not fire. Privilege code 2, a disabled kind, and an idle cycle carrying a matching address each have to stay silent.

// File: rtl/dtrig_pkg.sv
package dtrig_pkg;
  localparam int XLEN = 32;
  localparam int HALF = XLEN / 2;

  localparam int B_LOAD   = 0;
  localparam int B_STORE  = 1;
  localparam int B_EXEC   = 2;
  localparam int B_U      = 3;
  localparam int B_S      = 4;
  localparam int B_M      = 6;
  localparam int MODE_LO  = 7;
  localparam int MODE_HI  = 10;
  localparam int B_CHAIN  = 11;
  localparam int ACT_LO   = 12;
  localparam int ACT_HI   = 15;
  localparam int B_TIMING = 18;

  localparam logic [XLEN-1:0] CFG_KEEP = 32'h0004_FFDF;
  localparam logic [3:0] MODE_MAX   = 4'd5;
  localparam logic [3:0] ACT_DEBUG  = 4'd1;

  typedef enum logic [3:0] {
    M_EQ     = 4'd0,
    M_NAPOT  = 4'd1,
    M_GE     = 4'd2,
    M_LT     = 4'd3,
    M_LOHALF = 4'd4,
    M_HIHALF = 4'd5
  } match_e;

  typedef enum logic [1:0] {
    K_EXEC  = 2'd0,
    K_LOAD  = 2'd1,
    K_STORE = 2'd2,
    K_NONE  = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    P_USER  = 2'd0,
    P_SUPER = 2'd1,
    P_RSVD  = 2'd2,
    P_MACH  = 2'd3
  } priv_e;

  // Keep only supported fields; an unsupported mode or action zeroes the word.
  function automatic logic [XLEN-1:0] cfg_legalize(input logic [XLEN-1:0] w,
                                                   input logic last);
    logic [XLEN-1:0] r;
    r = w & CFG_KEEP;
    if (w[MODE_HI:MODE_LO] > MODE_MAX || w[ACT_HI:ACT_LO] != ACT_DEBUG) begin
      r = '0;
    end else if (last) begin
      r[B_CHAIN] = 1'b0;
    end
    return r;
  endfunction

  // Bits that must agree in a power-of-two region compare.
  function automatic logic [XLEN-1:0] napot_care(input logic [XLEN-1:0] cmp);
    return ~(cmp ^ (cmp + 1'b1));
  endfunction

  function automatic logic half_hit(input logic [HALF-1:0] part,
                                    input logic [XLEN-1:0] cmp);
    return (part & cmp[XLEN-1:HALF]) == cmp[HALF-1:0];
  endfunction

  function automatic logic addr_hit(input logic [3:0] mode,
                                    input logic [XLEN-1:0] addr,
                                    input logic [XLEN-1:0] cmp);
    logic h;
    case (mode)
      M_EQ:     h = (addr == cmp);
      M_NAPOT:  h = ((addr ^ cmp) & napot_care(cmp)) == '0;
      M_GE:     h = (addr >= cmp);
      M_LT:     h = (addr < cmp);
      M_LOHALF: h = half_hit(addr[HALF-1:0], cmp);
      M_HIHALF: h = half_hit(addr[XLEN-1:HALF], cmp);
      default:  h = 1'b0;
    endcase
    return h;
  endfunction
endpackage

// File: rtl/dtrig_cfg_regs.sv
module dtrig_cfg_regs
  import dtrig_pkg::*;
#(
  parameter int NUM_TRIG = 4,
  parameter int IDX_W    = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic                           wr_sel,
  input  logic [IDX_W-1:0]               wr_idx,
  input  logic [XLEN-1:0]                wr_data,
  input  logic                           rd_sel,
  input  logic [IDX_W-1:0]               rd_idx,
  output logic [XLEN-1:0]                rd_data,
  output logic [NUM_TRIG-1:0][XLEN-1:0]  cfg_q,
  output logic [NUM_TRIG-1:0][XLEN-1:0]  cmp_q
);
  for (genvar i = 0; i < NUM_TRIG; i++) begin : g_reg
    localparam logic IS_LAST = (i == NUM_TRIG - 1);
    logic sel_w;
    assign sel_w = wr_en && (int'(wr_idx) == i);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q[i] <= '0;
        cmp_q[i] <= '0;
      end else if (sel_w) begin
        if (wr_sel) cmp_q[i] <= wr_data;
        else        cfg_q[i] <= cfg_legalize(wr_data, IS_LAST);
      end
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_TRIG; i++) begin
      if (int'(rd_idx) == i) rd_data = rd_sel ? cmp_q[i] : cfg_q[i];
    end
  end
endmodule

// File: rtl/dtrig_cmp.sv
module dtrig_cmp
  import dtrig_pkg::*;
(
  input  logic [XLEN-1:0] cfg,
  input  logic [XLEN-1:0] cmp,
  input  logic            acc_valid,
  input  logic [1:0]      acc_kind,
  input  logic [1:0]      acc_priv,
  input  logic [XLEN-1:0] acc_addr,
  output logic            hit
);
  logic kind_ok, priv_ok, armed, where_ok;

  always_comb begin
    case (kind_e'(acc_kind))
      K_EXEC:  kind_ok = cfg[B_EXEC];
      K_LOAD:  kind_ok = cfg[B_LOAD];
      K_STORE: kind_ok = cfg[B_STORE];
      default: kind_ok = 1'b0;
    endcase
    case (priv_e'(acc_priv))
      P_USER:  priv_ok = cfg[B_U];
      P_SUPER: priv_ok = cfg[B_S];
      P_MACH:  priv_ok = cfg[B_M];
      default: priv_ok = 1'b0;
    endcase
  end

  assign armed    = (cfg[ACT_HI:ACT_LO] == ACT_DEBUG);
  assign where_ok = addr_hit(cfg[MODE_HI:MODE_LO], acc_addr, cmp);
  assign hit      = acc_valid && armed && kind_ok && priv_ok && where_ok;
endmodule

// File: rtl/dtrig_chain.sv
module dtrig_chain #(
  parameter int NUM_TRIG = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_TRIG-1:0] hit_vec,
  input  logic [NUM_TRIG-1:0] chain_vec,
  input  logic [NUM_TRIG-1:0] timing_vec,
  output logic [NUM_TRIG-1:0] group_ok,
  output logic [NUM_TRIG-1:0] fire_now,
  output logic                dbg_req_before,
  output logic                dbg_req_after,
  output logic [NUM_TRIG-1:0] fire_vec
);
  for (genvar i = 0; i < NUM_TRIG; i++) begin : g_link
    if (i == NUM_TRIG - 1) begin : g_tail
      assign group_ok[i] = hit_vec[i];
    end else begin : g_body
      assign group_ok[i] = hit_vec[i] && (!chain_vec[i] || group_ok[i+1]);
    end
    if (i == 0) begin : g_first
      assign fire_now[i] = group_ok[i];
    end else begin : g_next
      assign fire_now[i] = group_ok[i] && !chain_vec[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dbg_req_before <= 1'b0;
      dbg_req_after  <= 1'b0;
      fire_vec       <= '0;
    end else begin
      dbg_req_before <= |(fire_now & ~timing_vec);
      dbg_req_after  <= |(fire_now & timing_vec);
      fire_vec       <= fire_now;
    end
  end
endmodule

// File: rtl/dbg_trig_bank.sv
module dbg_trig_bank
  import dtrig_pkg::*;
#(
  parameter int NUM_TRIG = 4,
  localparam int IDX_W   = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                wr_sel,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic [31:0]         wr_data,
  input  logic                rd_sel,
  input  logic [IDX_W-1:0]    rd_idx,
  output logic [31:0]         rd_data,
  input  logic                acc_valid,
  input  logic [1:0]          acc_kind,
  input  logic [1:0]          acc_priv,
  input  logic [31:0]         acc_addr,
  output logic                dbg_req_before,
  output logic                dbg_req_after,
  output logic [NUM_TRIG-1:0] fire_vec
);
  logic [NUM_TRIG-1:0][XLEN-1:0] cfg_q;
  logic [NUM_TRIG-1:0][XLEN-1:0] cmp_q;
  logic [NUM_TRIG-1:0] hit_vec, chain_vec, timing_vec, group_ok, fire_now;

  dtrig_cfg_regs #(.NUM_TRIG(NUM_TRIG), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_idx(rd_idx), .rd_data(rd_data),
    .cfg_q(cfg_q), .cmp_q(cmp_q)
  );

  for (genvar i = 0; i < NUM_TRIG; i++) begin : g_trig
    assign chain_vec[i]  = cfg_q[i][B_CHAIN];
    assign timing_vec[i] = cfg_q[i][B_TIMING];
    dtrig_cmp u_cmp (
      .cfg(cfg_q[i]), .cmp(cmp_q[i]), .acc_valid(acc_valid),
      .acc_kind(acc_kind), .acc_priv(acc_priv), .acc_addr(acc_addr),
      .hit(hit_vec[i])
    );
  end

  dtrig_chain #(.NUM_TRIG(NUM_TRIG)) u_chain (
    .clk(clk), .rst_n(rst_n), .hit_vec(hit_vec), .chain_vec(chain_vec),
    .timing_vec(timing_vec), .group_ok(group_ok), .fire_now(fire_now),
    .dbg_req_before(dbg_req_before), .dbg_req_after(dbg_req_after),
    .fire_vec(fire_vec)
  );
endmodule

// File: rtl/dtrig_chk.sv
module dtrig_chk #(
  parameter int NUM_TRIG = 4,
  parameter int IDX_W    = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_en,
  input logic                wr_sel,
  input logic [IDX_W-1:0]    wr_idx,
  input logic [31:0]         wr_data,
  input logic                rd_sel,
  input logic [IDX_W-1:0]    rd_idx,
  input logic [31:0]         rd_data,
  input logic                acc_valid,
  input logic [1:0]          acc_priv,
  input logic                dbg_req_before,
  input logic                dbg_req_after,
  input logic [NUM_TRIG-1:0] fire_vec,
  input logic [NUM_TRIG-1:0] hit_vec
);
  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_sel |-> (rd_data[10:7] <= 4'd5)); // R2
  AST_ACTION_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_sel |-> (rd_data[15:13] == 3'd0)); // R2
  AST_LAST_UNCHAINED: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_sel && int'(rd_idx) == NUM_TRIG - 1) |-> !rd_data[11]); // R3
  AST_CMP_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en && wr_sel && rd_sel && wr_idx == rd_idx) && $stable(rd_idx) && $stable(rd_sel))
      |-> (rd_data == $past(wr_data))); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!acc_valid) |-> (!dbg_req_before && !dbg_req_after && fire_vec == '0)); // R12
  AST_RSVD_PRIV_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(acc_priv == 2'b10) |-> (!dbg_req_before && !dbg_req_after)); // R5
  AST_REQ_ONE_CYCLE_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_req_before || dbg_req_after) |-> (fire_vec != '0)); // R11
  for (genvar i = 0; i < NUM_TRIG; i++) begin : g_fire
    AST_FIRE_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      fire_vec[i] |-> $past(hit_vec[i])); // R10
  end
endmodule

bind dbg_trig_bank dtrig_chk #(.NUM_TRIG(NUM_TRIG), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx),
  .wr_data(wr_data), .rd_sel(rd_sel), .rd_idx(rd_idx), .rd_data(rd_data),
  .acc_valid(acc_valid), .acc_priv(acc_priv), .dbg_req_before(dbg_req_before),
  .dbg_req_after(dbg_req_after), .fire_vec(fire_vec), .hit_vec(hit_vec)
);

// File: tb/tb_dbg_trig_bank.sv
module tb_dbg_trig_bank;
  localparam int NT = 4;
  localparam int IW = 2;
  localparam int NVEC = 18;
  localparam int SET_A = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0, acc_valid = 1'b0;
  logic [IW-1:0] wr_idx = '0, rd_idx = '0;
  logic [31:0] wr_data = '0, acc_addr = '0, rd_data;
  logic [1:0] acc_kind = '0, acc_priv = '0;
  logic dbg_req_before, dbg_req_after;
  logic [NT-1:0] fire_vec;
  int checks = 0, failures = 0, cycles = 0;

  always #5 clk = ~clk;

  dbg_trig_bank #(.NUM_TRIG(NT)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_idx(rd_idx), .rd_data(rd_data),
    .acc_valid(acc_valid), .acc_kind(acc_kind), .acc_priv(acc_priv),
    .acc_addr(acc_addr), .dbg_req_before(dbg_req_before),
    .dbg_req_after(dbg_req_after), .fire_vec(fire_vec)
  );

  // {valid, kind, priv, addr, exp_before, exp_after, exp_fire}
  localparam logic [42:0] VEC [NVEC] = '{
    {1'b1, 2'd2, 2'd1, 32'h80007c80, 1'b1, 1'b0, 4'b0001}, // R8 R10 range start
    {1'b1, 2'd2, 2'd0, 32'h80007cef, 1'b1, 1'b0, 4'b0001}, // R8 last inside
    {1'b1, 2'd2, 2'd3, 32'h80007cf0, 1'b0, 1'b0, 4'b0000}, // R8 end exclusive
    {1'b1, 2'd2, 2'd3, 32'h80007c7f, 1'b0, 1'b0, 4'b0000}, // R10 below start
    {1'b1, 2'd1, 2'd3, 32'h80007c90, 1'b0, 1'b0, 4'b0000}, // R4 load not enabled
    {1'b1, 2'd2, 2'd1, 32'h81230000, 1'b1, 1'b0, 4'b0100}, // R7 region low
    {1'b1, 2'd2, 2'd0, 32'h8123ffff, 1'b1, 1'b0, 4'b0100}, // R7 region high
    {1'b1, 2'd2, 2'd0, 32'h81240000, 1'b0, 1'b0, 4'b0000}, // R7 above region
    {1'b1, 2'd0, 2'd3, 32'h80001234, 1'b0, 1'b1, 4'b1000}, // R6 R11 exec after
    {1'b1, 2'd0, 2'd1, 32'h80001234, 1'b0, 1'b0, 4'b0000}, // R5 S not enabled
    {1'b1, 2'd0, 2'd3, 32'h80001238, 1'b0, 1'b0, 4'b0000}, // R6 not equal
    {1'b1, 2'd2, 2'd2, 32'h81230010, 1'b0, 1'b0, 4'b0000}, // R5 reserved priv
    {1'b0, 2'd0, 2'd3, 32'h80001234, 1'b0, 1'b0, 4'b0000}, // R12 idle
    {1'b1, 2'd1, 2'd1, 32'h86753095, 1'b0, 1'b1, 4'b0001}, // R9 both halves
    {1'b1, 2'd1, 2'd0, 32'h9675309f, 1'b0, 1'b1, 4'b0001}, // R9 masked high bit
    {1'b1, 2'd1, 2'd3, 32'h867530a0, 1'b0, 1'b0, 4'b0000}, // R9 low half misses
    {1'b1, 2'd1, 2'd3, 32'h76753090, 1'b0, 1'b0, 4'b0000}, // R10 only low half hits
    {1'b1, 2'd2, 2'd3, 32'h81230004, 1'b1, 1'b0, 4'b0100}  // R7 kept after reconfig
  };

  function automatic string tag_of(input int i);
    case (i)
      0, 1, 2: return "R8";
      3, 16:   return "R10";
      4:       return "R4";
      5, 6, 7, 17: return "R7";
      8:       return "R11";
      9, 11:   return "R5";
      10:      return "R6";
      12:      return "R12";
      default: return "R9";
    endcase
  endfunction

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        failures++;
        $display("FAIL watchdog: R12 run hung, actual cycles=%0d expected < 20000", cycles);
        summary();
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input int idx, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_idx = IW'(idx); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic sel, input int idx,
                          input logic [31:0] exp);
    rd_sel = sel; rd_idx = IW'(idx);
    #1;
    check(req, rd_data, exp);
  endtask

  task automatic access(input logic v, input logic [1:0] k, input logic [1:0] p,
                        input logic [31:0] a);
    @(negedge clk);
    acc_valid = v; acc_kind = k; acc_priv = p; acc_addr = a;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  function automatic logic [31:0] outs();
    return {26'd0, dbg_req_before, dbg_req_after, fire_vec};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12", outs(), 32'd0);
    rd_check("R12", 1'b0, 2, 32'd0);
    rd_check("R12", 1'b1, 2, 32'd0);
    rst_n = 1'b1;

    // Set A: store range on 0/1, region on 2, exec breakpoint on 3
    wr(1'b0, 0, 32'h0000_195a); wr(1'b1, 0, 32'h8000_7c80);
    wr(1'b0, 1, 32'h0000_11da); wr(1'b1, 1, 32'h8000_7cf0);
    wr(1'b0, 2, 32'h0000_10da); wr(1'b1, 2, 32'h8123_7fff);
    wr(1'b0, 3, 32'h0004_1044); wr(1'b1, 3, 32'h8000_1234);
    rd_check("R1", 1'b0, 0, 32'h0000_195a);
    rd_check("R1", 1'b1, 2, 32'h8123_7fff);
    rd_check("R1", 1'b0, 3, 32'h0004_1044);

    for (int i = 0; i < NVEC; i++) begin
      if (i == SET_A) begin
        wr(1'b0, 0, 32'h0004_1a59); wr(1'b1, 0, 32'hfff0_3090);
        wr(1'b0, 1, 32'h0004_12d9); wr(1'b1, 1, 32'hefff_8675);
      end
      access(VEC[i][42], VEC[i][41:40], VEC[i][39:38], VEC[i][37:6]);
      check(tag_of(i), outs(), {26'd0, VEC[i][5:0]});
    end

    // R1 unused bits are dropped
    wr(1'b0, 2, 32'hfff0_10fa);
    rd_check("R1", 1'b0, 2, 32'h0000_10da);
    // R3 chain on the last trigger is cleared, rest kept
    wr(1'b0, 3, 32'h0000_195a);
    rd_check("R3", 1'b0, 3, 32'h0000_115a);
    // R3 last trigger behaves as a lone >= compare
    wr(1'b1, 3, 32'h9000_0000);
    access(1'b1, 2'd2, 2'd3, 32'h9000_0000);
    check("R3", outs(), {26'd0, 1'b1, 1'b0, 4'b1000});
    // R2 unsupported match mode 6
    wr(1'b0, 3, 32'h0000_135a);
    rd_check("R2", 1'b0, 3, 32'd0);
    access(1'b1, 2'd2, 2'd3, 32'h9000_0000);
    check("R2", outs(), 32'd0);
    // R2 unsupported action 2
    wr(1'b0, 2, 32'h0000_20da);
    rd_check("R2", 1'b0, 2, 32'd0);
    access(1'b1, 2'd2, 2'd3, 32'h8123_0000);
    check("R2", outs(), 32'd0);
    // R11 before timing on a single equal trigger
    wr(1'b0, 2, 32'h0000_1044); wr(1'b1, 2, 32'h0000_0100);
    access(1'b1, 2'd0, 2'd3, 32'h0000_0100);
    check("R11", outs(), {26'd0, 1'b1, 1'b0, 4'b0100});
    // R12 reset in mid-run clears the registers
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    rd_check("R12", 1'b1, 0, 32'd0);
    rd_check("R12", 1'b0, 0, 32'd0);
    rst_n = 1'b1;
    summary();
  end
endmodule